// File: doc/BRIEF.md
# External Bus Chip-Select Generator

This block produces the active-low select lines that an external bus controller uses to pick one external memory or peripheral, so that no decoder is needed outside the chip. Each select line has an address window. A window is a base address and a power-of-two size given as log2. A 2-bit strap code is captured while reset is held. It decides whether the select lines exist at all. A software bit hands the second pin over to its select function.

The lines are updated only when a bus cycle starts. An external cycle drives low the select line of the first matching window and drives every other line high. An on-chip peripheral cycle drives all lines high. An internal cycle leaves the lines as they are. A small state machine holds the result between cycles. Its states are ST_IDLE (no line selected) and ST_SEL (one line selected, its index held in a register). Its transitions are:

- SELECT: an external cycle hits a window, from either state into ST_SEL.
- MISS: an external cycle hits no window, into ST_IDLE.
- PERIPH: a peripheral cycle, into ST_IDLE.
- OFF: the lines are disabled by the strap, into ST_IDLE.
- HOLD: an internal cycle or no cycle, and the state stays where it is.

Top module: `cs_select_gen`

## Requirements
- R1: While rst_n is low, and at the first sample after rst_n is released, every bit of cs_n is 1.
- R2: strap_code is sampled only on clock edges with rst_n low. Code 2'b01 enables the lines. Code 2'b10 disables them. Codes 2'b00 and 2'b11 are reserved and act like 2'b10. A change of strap_code after reset has no effect.
- R3: On the clock edge that samples cyc_start=1 with cyc_kind=2'b01 (external), and with the lines enabled, the line of the matching window goes low and all other lines go high. This is visible right after that edge. At most one line is ever low.
- R4: When windows overlap, only the lowest-indexed matching window's line goes low.
- R5: An external cycle whose address matches no window drives all lines high.
- R6: A cycle with cyc_kind=2'b00 (internal) or 2'b11 (treated as internal) leaves cs_n unchanged, even if the address lies inside a window.
- R7: A cycle with cyc_kind=2'b10 (on-chip peripheral) drives all lines high.
- R8: With the lines disabled, cs_n stays all 1 for every cycle type and pin_mode is all 0.
- R9: With the lines enabled, pin_mode[0] is 1 and pin_mode[1] follows alt_en[0]. Line 1 is held high while alt_en[0] is 0. The gate on line 1 is applied at the next clock edge, and the selection already held is kept.
- R10: Window i matches when the address and win_base[i] agree on all bits at or above bit win_size[i]. The window is therefore 2^win_size[i] bytes and includes both of its end addresses.
- R11: Without cyc_start, cs_n keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap is captured while low |
| strap_code | input | 2 | Line-count strap code |
| win_base | input | NUM_WIN*ADDR_W | Window base addresses, window i at bits [i*ADDR_W +: ADDR_W] |
| win_size | input | NUM_WIN*SZ_W | Window size as log2 bytes, window i at bits [i*SZ_W +: SZ_W] |
| cyc_start | input | 1 | Start-of-bus-cycle strobe |
| cyc_kind | input | 2 | Cycle type: 00 internal, 01 external, 10 peripheral, 11 internal |
| cyc_addr | input | ADDR_W | Address of the starting cycle |
| alt_en | input | NUM_WIN-1 | Pin select-function enables for lines 1 and up |
| cs_n | output | NUM_WIN | Active-low chip-select lines |
| pin_mode | output | NUM_WIN | 1 where a pin acts as a chip select, 0 where it is general-purpose I/O |

## Verification
Every change of cs_n, whether from a cycle strobe or from alt_en, goes through a single output register. The new value is therefore due one clock edge after the input is sampled. pin_mode follows the strap register and alt_en without any register in between. The bench drives inputs on the falling edge and samples on the next falling edge, one rising edge later. Checks of the hold behaviour then wait several further edges and sample again, so that no change can arrive late.

// File: rtl/cs_gen_pkg.sv
package cs_gen_pkg;

    typedef enum logic [1:0] {
        ACC_INT  = 2'b00,
        ACC_EXT  = 2'b01,
        ACC_PERI = 2'b10,
        ACC_RSV  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEL  = 1'b1
    } cs_state_e;

    localparam logic [1:0] STRAP_LINES_ON = 2'b01;

endpackage

// File: rtl/cs_strap_latch.sv
module cs_strap_latch
    import cs_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_code,
    output logic       lines_on
);

    // Captured on edges while reset is held; the flop keeps its value afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_on <= (strap_code == STRAP_LINES_ON);
        end
    end

endmodule

// File: rtl/cs_win_match.sv
module cs_win_match #(
    parameter int ADDR_W = 24,
    parameter int SZ_W   = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_log2,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W-1:0] keep_mask;

    always_comb begin
        for (int b = 0; b < ADDR_W; b++) begin
            keep_mask[b] = (b >= int'(size_log2));
        end
        hit = ((addr & keep_mask) == (base & keep_mask));
    end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic [N-1:0]     hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any_hit = |hits;
        idx     = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hits[k]) begin
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/cs_select_gen.sv
module cs_select_gen
    import cs_gen_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_WIN = 2,
    parameter int SZ_W    = $clog2(ADDR_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                strap_code,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*SZ_W-1:0]   win_size,
    input  logic                      cyc_start,
    input  logic [1:0]                cyc_kind,
    input  logic [ADDR_W-1:0]         cyc_addr,
    input  logic [NUM_WIN-2:0]        alt_en,
    output logic [NUM_WIN-1:0]        cs_n,
    output logic [NUM_WIN-1:0]        pin_mode
);

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic              lines_on;
    logic [NUM_WIN-1:0] win_hit;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [NUM_WIN-1:0] line_en;

    cs_state_e         state_q, state_nxt;
    logic [IDX_W-1:0]  sel_q, sel_nxt;
    logic [NUM_WIN-1:0] cs_n_q;

    cs_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_code (strap_code),
        .lines_on   (lines_on)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            cs_win_match #(
                .ADDR_W (ADDR_W),
                .SZ_W   (SZ_W)
            ) u_match (
                .base      (win_base[w*ADDR_W +: ADDR_W]),
                .size_log2 (win_size[w*SZ_W +: SZ_W]),
                .addr      (cyc_addr),
                .hit       (win_hit[w])
            );
        end
    endgenerate

    cs_prio_pick #(
        .N     (NUM_WIN),
        .IDX_W (IDX_W)
    ) u_pick (
        .hits    (win_hit),
        .any_hit (any_hit),
        .idx     (hit_idx)
    );

    // Line 0 is driven automatically; higher lines need their pin function enabled.
    assign line_en[0] = lines_on;
    generate
        for (genvar l = 1; l < NUM_WIN; l++) begin : g_gate
            assign line_en[l] = lines_on & alt_en[l-1];
        end
    endgenerate

    // Transition selection: SELECT, MISS, PERIPH, OFF, HOLD.
    always_comb begin
        state_nxt = state_q;
        sel_nxt   = sel_q;
        if (!lines_on) begin
            state_nxt = ST_IDLE;                       // OFF
        end else if (cyc_start) begin
            unique case (acc_kind_e'(cyc_kind))
                ACC_EXT: begin
                    if (any_hit) begin
                        state_nxt = ST_SEL;            // SELECT
                        sel_nxt   = hit_idx;
                    end else begin
                        state_nxt = ST_IDLE;           // MISS
                    end
                end
                ACC_PERI: state_nxt = ST_IDLE;         // PERIPH
                ACC_INT,
                ACC_RSV:  state_nxt = state_q;         // HOLD
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_nxt;
            sel_q   <= sel_nxt;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= '1;
        end else begin
            for (int l = 0; l < NUM_WIN; l++) begin
                cs_n_q[l] <= !((state_nxt == ST_SEL) && (sel_nxt == IDX_W'(l)) && line_en[l]);
            end
        end
    end

    assign cs_n     = cs_n_q;
    assign pin_mode = line_en;

endmodule

// File: rtl/cs_select_gen_chk.sv
module cs_select_gen_chk #(
    parameter int NUM_WIN = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_start,
    input logic [1:0]         cyc_kind,
    input logic [NUM_WIN-2:0] alt_en,
    input logic [NUM_WIN-1:0] cs_n,
    input logic [NUM_WIN-1:0] pin_mode
);

    // R1
    reset_high_chk: assert property (@(posedge clk) !rst_n |=> (&cs_n));

    // R3
    one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R7
    periph_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_kind == 2'b10) |=> (&cs_n));

    // R8
    lines_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode[0] |-> (&cs_n));

    // R9
    gate_line1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en[0] |=> cs_n[1]);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cyc_start || cyc_kind == 2'b00 || cyc_kind == 2'b11) && $stable(alt_en))
        |=> $stable(cs_n));

endmodule

bind cs_select_gen cs_select_gen_chk #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_kind  (cyc_kind),
    .alt_en    (alt_en),
    .cs_n      (cs_n),
    .pin_mode  (pin_mode)
);

// File: tb/cs_select_gen_tb.sv
module cs_select_gen_tb_top;

    localparam int ADDR_W  = 24;
    localparam int NUM_WIN = 2;
    localparam int SZ_W    = $clog2(ADDR_W + 1);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [1:0]                strap_code = 2'b01;
    logic [NUM_WIN*ADDR_W-1:0] win_base = '0;
    logic [NUM_WIN*SZ_W-1:0]   win_size = '0;
    logic                      cyc_start = 1'b0;
    logic [1:0]                cyc_kind = 2'b00;
    logic [ADDR_W-1:0]         cyc_addr = '0;
    logic [NUM_WIN-2:0]        alt_en = '0;
    logic [NUM_WIN-1:0]        cs_n;
    logic [NUM_WIN-1:0]        pin_mode;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cs_select_gen #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_code(strap_code),
        .win_base(win_base), .win_size(win_size),
        .cyc_start(cyc_start), .cyc_kind(cyc_kind), .cyc_addr(cyc_addr),
        .alt_en(alt_en), .cs_n(cs_n), .pin_mode(pin_mode)
    );

    task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_win(input int w, input logic [ADDR_W-1:0] base, input int sz);
        win_base[w*ADDR_W +: ADDR_W] = base;
        win_size[w*SZ_W +: SZ_W]     = SZ_W'(sz);
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst_n      = 1'b0;
        strap_code = code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [1:0] kind, input logic [ADDR_W-1:0] addr);
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_kind  = kind;
        cyc_addr  = addr;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic t_reset;
        alt_en = 1'b0;
        do_reset(2'b01);
        check2("R1 after reset", cs_n, 2'b11);
        check2("R9 pin mode line1 off", pin_mode, 2'b01);
    endtask

    task automatic t_select;
        alt_en = 1'b1;
        set_win(0, 24'h100000, 20);
        set_win(1, 24'h400000, 16);
        @(negedge clk);
        check2("R9 pin mode both", pin_mode, 2'b11);
        bus_cycle(2'b01, 24'h123456);
        check2("R3 window0", cs_n, 2'b10);
        bus_cycle(2'b01, 24'h40FFFF);
        check2("R3 R10 window1 top end", cs_n, 2'b01);
        bus_cycle(2'b01, 24'h410000);
        check2("R5 R10 just past window1", cs_n, 2'b11);
        bus_cycle(2'b01, 24'h1FFFFF);
        check2("R10 window0 top end", cs_n, 2'b10);
        bus_cycle(2'b01, 24'h0FFFFF);
        check2("R5 R10 just below window0", cs_n, 2'b11);
    endtask

    task automatic t_hold;
        bus_cycle(2'b01, 24'h400000);
        check2("R3 window1 base", cs_n, 2'b01);
        bus_cycle(2'b00, 24'h100000);
        check2("R6 internal holds", cs_n, 2'b01);
        bus_cycle(2'b11, 24'h100000);
        check2("R6 kind 11 holds", cs_n, 2'b01);
        repeat (5) @(negedge clk);
        check2("R11 idle holds", cs_n, 2'b01);
    endtask

    task automatic t_periph;
        bus_cycle(2'b10, 24'h400000);
        check2("R7 peripheral deselects", cs_n, 2'b11);
        bus_cycle(2'b01, 24'h100000);
        check2("R3 reselect after peripheral", cs_n, 2'b10);
    endtask

    task automatic t_prio;
        set_win(1, 24'h180000, 19);
        bus_cycle(2'b01, 24'h180000);
        check2("R4 overlap picks window0", cs_n, 2'b10);
        set_win(1, 24'h400000, 16);
    endtask

    task automatic t_gate;
        alt_en = 1'b0;
        bus_cycle(2'b01, 24'h400000);
        check2("R9 line1 gated", cs_n, 2'b11);
        check2("R9 pin mode gated", pin_mode, 2'b01);
        alt_en = 1'b1;
        @(negedge clk);
        check2("R9 line1 released", cs_n, 2'b01);
        check2("R9 pin mode released", pin_mode, 2'b11);
    endtask

    task automatic t_modes;
        do_reset(2'b10);
        bus_cycle(2'b01, 24'h100000);
        check2("R8 no lines", cs_n, 2'b11);
        check2("R8 pin mode gpio", pin_mode, 2'b00);
        do_reset(2'b00);
        bus_cycle(2'b01, 24'h100000);
        check2("R2 reserved 00", cs_n, 2'b11);
        do_reset(2'b11);
        bus_cycle(2'b01, 24'h400000);
        check2("R2 reserved 11", cs_n, 2'b11);
        check2("R2 reserved pin mode", pin_mode, 2'b00);
        do_reset(2'b01);
        strap_code = 2'b10;
        bus_cycle(2'b01, 24'h100000);
        check2("R2 strap ignored after reset", cs_n, 2'b10);
    endtask

    initial begin
        t_reset();
        t_select();
        t_hold();
        t_periph();
        t_prio();
        t_gate();
        t_modes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule